// File: doc/BRIEF.md
# Memory Ordering Queues for Out-of-Order Loads and Stores

This block tracks in-flight memory operations for an out-of-order core. Loads and stores are allocated in program order into two separate queues. Each allocation receives a sequence tag (its age) from a wrapping counter. A load's address is known when it is allocated. A store learns its address and data later, when its address resolves. Loads may issue before older stores have resolved. When a load issues, the block searches the older resolved stores in the same cycle. It then forwards data, reads memory, or holds the load back.

The block also polices ordering after the fact. When a store resolves onto an address that a younger load has already read, the block raises a replay. It does the same when an issuing load finds a younger load to the same location that has already issued. The replay output names the oldest offending load. That load and every younger load return to the not-issued state, so they can be re-executed. A store may only be handed on toward memory once no older, not-yet-issued load touches the same location. Entries leave the queues one at a time, oldest first, through a retire strobe.

Addresses are byte addresses of 32-bit words, and bit 0 is ignored. Two accesses overlap when they fall in the same word (all address bits above bit 1 are equal) and either one is a word access, or both are halfwords with equal bit 1.

Top module: `lsq_disambig`

## Requirements
- R1: After reset, no replay is signalled, no load result is presented, `st_issue_ok` is 0, `alloc_age` is 0 and `alloc_ready` is 1.
- R2: Each accepted allocation receives the current `alloc_age`, which then advances by one, wrapping modulo 2^AGE_W. `alloc_ready` is 0 when the queue chosen by `alloc_store` already holds its full count of entries (LQ_N loads or SQ_N stores).
- R3: An issuing load whose youngest older, resolved, overlapping store can cover it takes that store's data on `ld_fwd_data` with `ld_fwd_hit`=1. The data depends on the sizes. A word store to a word load gives the full word. A word store to a halfword load gives bits 31:16 when load address bit 1 is 1 and bits 15:0 otherwise. A halfword store to a halfword load gives store data bits 15:0. Halfword results are zero-extended.
- R4: Stores that are unresolved, younger than the load, or non-overlapping are ignored by an issuing load. If no store qualifies, the load asserts `ld_mem_rd` and does not forward.
- R5: When the youngest older overlapping store is a halfword and the load is a word, the load asserts `ld_stall` with neither forwarding nor memory read. The stalled load stays not-issued.
- R6: In the cycle a store resolves, `replay_valid` rises with `replay_cause[0]`=1 if any younger load that has issued, or is issuing in that cycle, overlaps the store. `replay_age` is then the age of the oldest such load.
- R7: In the cycle a load issues, `replay_valid` rises with `replay_cause[1]`=1 if a younger overlapping load has already issued. `replay_age` is then the oldest such younger load.
- R8: After a replay, the named load and all younger loads are not-issued. A later store resolving onto their addresses raises no replay until they issue again.
- R9: `st_issue_ok` is 1 for a queried store only if that store is resolved and no older, not-issued load overlaps it.
- R10: A retire strobe frees the oldest in-flight entry, and its queue slot becomes available for allocation again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_store | input | 1 | 1 = store, 0 = load |
| alloc_word | input | 1 | 1 = word access, 0 = halfword |
| alloc_addr | input | ADDR_W | Load address (ignored for stores) |
| alloc_ready | output | 1 | Target queue has room |
| alloc_age | output | AGE_W | Age given to the next allocation |
| ld_iss_valid | input | 1 | A load issues this cycle |
| ld_iss_age | input | AGE_W | Age of the issuing load |
| ld_fwd_hit | output | 1 | Data forwarded from a store |
| ld_fwd_data | output | DATA_W | Forwarded data |
| ld_stall | output | 1 | Load must wait for a narrow store |
| ld_mem_rd | output | 1 | Load reads memory |
| st_res_valid | input | 1 | A store resolves its address |
| st_res_age | input | AGE_W | Age of the resolving store |
| st_res_addr | input | ADDR_W | Store address |
| st_res_data | input | DATA_W | Store data |
| st_chk_valid | input | 1 | Query whether a store may proceed |
| st_chk_age | input | AGE_W | Age of the queried store |
| st_issue_ok | output | 1 | Queried store may proceed |
| replay_valid | output | 1 | A load must be replayed |
| replay_age | output | AGE_W | Oldest load to replay |
| replay_cause | output | 2 | Bit 0 store conflict, bit 1 load-load order |
| retire_valid | input | 1 | Free the oldest entry |

## Verification
Forwarding is exercised with two resolved stores to the same word, so a design that picked the oldest match instead of the youngest would return the stale word. Both halves of a word store are read back through halfword loads to catch a swapped half selection, and a word load behind a halfword store must stall rather than forward a partial value. Replays are provoked with two flagged loads, so a design that reports the youngest offender gives the wrong age. A second store is then resolved onto an already-replayed load; a design that left the issued bits set would raise a spurious replay there. Store ordering is queried before and after the older load issues, and queue-full and retire are checked at the allocation port.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  parameter int ADDR_W = 16;
  parameter int DATA_W = 32;
  parameter int AGE_W  = 6;
  localparam int HALF_W = DATA_W / 2;

  typedef logic [AGE_W-1:0]  age_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef struct packed {
    logic  valid;
    age_t  age;
    addr_t addr;
    logic  word;
    logic  issued;
  } lq_ent_t;

  typedef struct packed {
    logic  valid;
    age_t  age;
    addr_t addr;
    logic  word;
    logic  resolved;
    data_t data;
  } sq_ent_t;

  // a precedes b in program order (wrapping tag, window below half range)
  function automatic logic is_older(age_t a, age_t b);
    age_t d;
    d = b - a;
    return (d != '0) && !d[AGE_W-1];
  endfunction

  function automatic logic overlaps(addr_t pa, logic pw, addr_t qa, logic qw);
    return (pa[ADDR_W-1:2] == qa[ADDR_W-1:2]) && (pw || qw || (pa[1] == qa[1]));
  endfunction

  // given overlap: a store can supply the load unless it is narrower
  function automatic logic can_forward(logic st_word, logic ld_word);
    return st_word || !ld_word;
  endfunction

  function automatic data_t fwd_value(data_t sd, logic st_word, addr_t la, logic ld_word);
    if (ld_word) return sd;
    if (st_word && la[1]) return {{HALF_W{1'b0}}, sd[DATA_W-1:HALF_W]};
    return {{HALF_W{1'b0}}, sd[HALF_W-1:0]};
  endfunction
endpackage

// File: rtl/lsq_age_select.sv
module lsq_age_select
  import lsq_pkg::*;
#(
  parameter int N = 4,
  parameter bit YOUNGEST = 1'b0,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             [N-1:0] mask,
  input  age_t             [N-1:0] ages,
  output logic                     any,
  output logic             [IW-1:0] idx,
  output age_t                     sel_age
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (mask[i]) begin
        if (!any) begin
          any = 1'b1;
          idx = IW'(i);
        end else if (YOUNGEST ? is_older(ages[idx], ages[i]) : is_older(ages[i], ages[idx])) begin
          idx = IW'(i);
        end
      end
    end
    sel_age = ages[idx];
  end
endmodule

// File: rtl/lsq_store_queue.sv
module lsq_store_queue
  import lsq_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  alloc_en,
  input  age_t  alloc_age,
  input  logic  alloc_word,
  input  logic  res_en,
  input  age_t  res_age,
  input  addr_t res_addr,
  input  data_t res_data,
  input  logic  free_en,
  input  age_t  free_age,
  input  logic  srch_en,
  input  age_t  srch_age,
  input  addr_t srch_addr,
  input  logic  srch_word,
  input  age_t  chk_age,
  output logic  full,
  output logic  res_word,
  output logic  fwd_hit,
  output data_t fwd_data,
  output logic  fwd_stall,
  output logic  chk_found,
  output logic  chk_ready,
  output addr_t chk_addr,
  output logic  chk_word
);
  sq_ent_t q [N];
  logic [N-1:0] busy, match;
  age_t [N-1:0] ages;
  logic [IW-1:0] slot, hit_idx;
  logic hit_any;
  age_t hit_age;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign busy[g]  = q[g].valid;
    assign ages[g]  = q[g].age;
    assign match[g] = q[g].valid && q[g].resolved && is_older(q[g].age, srch_age)
                      && overlaps(q[g].addr, q[g].word, srch_addr, srch_word);
  end

  assign full = &busy;

  always_comb begin
    slot = '0;
    for (int i = N - 1; i >= 0; i--) if (!busy[i]) slot = IW'(i);
  end

  lsq_age_select #(.N(N), .YOUNGEST(1'b1)) u_pick (
    .mask(match), .ages(ages), .any(hit_any), .idx(hit_idx), .sel_age(hit_age)
  );

  assign fwd_hit   = srch_en && hit_any && can_forward(q[hit_idx].word, srch_word);
  assign fwd_stall = srch_en && hit_any && !can_forward(q[hit_idx].word, srch_word);
  assign fwd_data  = fwd_hit ? fwd_value(q[hit_idx].data, q[hit_idx].word, srch_addr, srch_word) : '0;

  always_comb begin
    res_word  = 1'b0;
    chk_found = 1'b0;
    chk_ready = 1'b0;
    chk_addr  = '0;
    chk_word  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (q[i].valid && q[i].age == res_age) res_word = q[i].word;
      if (q[i].valid && q[i].age == chk_age) begin
        chk_found = 1'b1;
        chk_ready = q[i].resolved;
        chk_addr  = q[i].addr;
        chk_word  = q[i].word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (alloc_en && slot == IW'(i)) begin
          q[i] <= '{1'b1, alloc_age, '0, alloc_word, 1'b0, '0};
        end else begin
          if (free_en && q[i].valid && q[i].age == free_age) q[i].valid <= 1'b0;
          if (res_en && q[i].valid && q[i].age == res_age) begin
            q[i].addr     <= res_addr;
            q[i].data     <= res_data;
            q[i].resolved <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/lsq_load_queue.sv
module lsq_load_queue
  import lsq_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alloc_en,
  input  age_t        alloc_age,
  input  addr_t       alloc_addr,
  input  logic        alloc_word,
  input  logic        iss_en,
  input  age_t        iss_age,
  input  logic        iss_stall,
  input  logic        sr_en,
  input  age_t        sr_age,
  input  addr_t       sr_addr,
  input  logic        sr_word,
  input  age_t        chk_age,
  input  addr_t       chk_addr,
  input  logic        chk_word,
  input  logic        free_en,
  input  age_t        free_age,
  output logic        full,
  output logic        iss_found,
  output addr_t       iss_addr,
  output logic        iss_word,
  output logic        rp_valid,
  output age_t        rp_age,
  output logic [1:0]  rp_cause,
  output logic        chk_block
);
  lq_ent_t q [N];
  logic [N-1:0] busy, hit, st_m, ll_m, blk, issued_nxt;
  age_t [N-1:0] ages;
  logic [IW-1:0] slot, rp_idx;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign busy[g] = q[g].valid;
    assign ages[g] = q[g].age;
    assign hit[g]  = iss_en && q[g].valid && q[g].age == iss_age;
    // store resolution against loads that read (or read now) the location
    assign st_m[g] = sr_en && q[g].valid && (q[g].issued || hit[g])
                     && is_older(sr_age, q[g].age)
                     && overlaps(sr_addr, sr_word, q[g].addr, q[g].word);
    // an issuing load meets a younger load that went first
    assign ll_m[g] = iss_found && q[g].valid && q[g].issued
                     && is_older(iss_age, q[g].age)
                     && overlaps(iss_addr, iss_word, q[g].addr, q[g].word);
    assign blk[g]  = q[g].valid && !q[g].issued && is_older(q[g].age, chk_age)
                     && overlaps(chk_addr, chk_word, q[g].addr, q[g].word);
    assign issued_nxt[g] = (q[g].issued || (hit[g] && !iss_stall))
                           && !(rp_valid && !is_older(q[g].age, rp_age));
  end

  assign full      = &busy;
  assign iss_found = |hit;
  assign chk_block = |blk;

  always_comb begin
    slot     = '0;
    iss_addr = '0;
    iss_word = 1'b0;
    for (int i = N - 1; i >= 0; i--) if (!busy[i]) slot = IW'(i);
    for (int i = 0; i < N; i++) begin
      if (hit[i]) begin
        iss_addr = q[i].addr;
        iss_word = q[i].word;
      end
    end
  end

  lsq_age_select #(.N(N), .YOUNGEST(1'b0)) u_pick (
    .mask(st_m | ll_m), .ages(ages), .any(rp_valid), .idx(rp_idx), .sel_age(rp_age)
  );

  assign rp_cause = rp_valid ? {ll_m[rp_idx], st_m[rp_idx]} : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (alloc_en && slot == IW'(i)) begin
          q[i] <= '{1'b1, alloc_age, alloc_addr, alloc_word, 1'b0};
        end else begin
          if (free_en && q[i].valid && q[i].age == free_age) q[i].valid <= 1'b0;
          q[i].issued <= issued_nxt[i];
        end
      end
    end
  end
endmodule

// File: rtl/lsq_disambig.sv
module lsq_disambig
  import lsq_pkg::*;
#(
  parameter int LQ_N = 4,
  parameter int SQ_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_store,
  input  logic              alloc_word,
  input  logic [ADDR_W-1:0] alloc_addr,
  output logic              alloc_ready,
  output logic [AGE_W-1:0]  alloc_age,
  input  logic              ld_iss_valid,
  input  logic [AGE_W-1:0]  ld_iss_age,
  output logic              ld_fwd_hit,
  output logic [DATA_W-1:0] ld_fwd_data,
  output logic              ld_stall,
  output logic              ld_mem_rd,
  input  logic              st_res_valid,
  input  logic [AGE_W-1:0]  st_res_age,
  input  logic [ADDR_W-1:0] st_res_addr,
  input  logic [DATA_W-1:0] st_res_data,
  input  logic              st_chk_valid,
  input  logic [AGE_W-1:0]  st_chk_age,
  output logic              st_issue_ok,
  output logic              replay_valid,
  output logic [AGE_W-1:0]  replay_age,
  output logic [1:0]        replay_cause,
  input  logic              retire_valid
);
  age_t  next_age, head_age;
  logic  lq_full, sq_full, alloc_fire, retire_fire;
  logic  ld_found, ld_word, st_word;
  addr_t ld_addr, chk_addr;
  logic  chk_found, chk_ready, chk_word, chk_block;

  assign alloc_ready = alloc_store ? !sq_full : !lq_full;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign retire_fire = retire_valid && (head_age != next_age);
  assign alloc_age   = next_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_age <= '0;
      head_age <= '0;
    end else begin
      if (alloc_fire)  next_age <= next_age + 1'b1;
      if (retire_fire) head_age <= head_age + 1'b1;
    end
  end

  lsq_load_queue #(.N(LQ_N)) u_lq (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_fire && !alloc_store), .alloc_age(next_age),
    .alloc_addr(alloc_addr), .alloc_word(alloc_word),
    .iss_en(ld_iss_valid), .iss_age(ld_iss_age), .iss_stall(ld_stall),
    .sr_en(st_res_valid), .sr_age(st_res_age), .sr_addr(st_res_addr), .sr_word(st_word),
    .chk_age(st_chk_age), .chk_addr(chk_addr), .chk_word(chk_word),
    .free_en(retire_fire), .free_age(head_age),
    .full(lq_full), .iss_found(ld_found), .iss_addr(ld_addr), .iss_word(ld_word),
    .rp_valid(replay_valid), .rp_age(replay_age), .rp_cause(replay_cause),
    .chk_block(chk_block)
  );

  lsq_store_queue #(.N(SQ_N)) u_sq (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_fire && alloc_store), .alloc_age(next_age), .alloc_word(alloc_word),
    .res_en(st_res_valid), .res_age(st_res_age), .res_addr(st_res_addr), .res_data(st_res_data),
    .free_en(retire_fire), .free_age(head_age),
    .srch_en(ld_found), .srch_age(ld_iss_age), .srch_addr(ld_addr), .srch_word(ld_word),
    .chk_age(st_chk_age),
    .full(sq_full), .res_word(st_word), .fwd_hit(ld_fwd_hit), .fwd_data(ld_fwd_data),
    .fwd_stall(ld_stall), .chk_found(chk_found), .chk_ready(chk_ready),
    .chk_addr(chk_addr), .chk_word(chk_word)
  );

  assign ld_mem_rd   = ld_found && !ld_fwd_hit && !ld_stall;
  assign st_issue_ok = st_chk_valid && chk_found && chk_ready && !chk_block;
endmodule

// File: rtl/lsq_disambig_chk.sv
module lsq_disambig_chk
  import lsq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       alloc_fire,
  input age_t       alloc_age,
  input logic       ld_fwd_hit,
  input logic       ld_stall,
  input logic       ld_mem_rd,
  input logic       ld_iss_valid,
  input age_t       ld_iss_age,
  input logic       st_res_valid,
  input age_t       st_res_age,
  input logic       st_chk_valid,
  input logic       st_issue_ok,
  input logic       replay_valid,
  input age_t       replay_age,
  input logic [1:0] replay_cause
);
  a_r1_replay_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> replay_cause != 2'b00);
  a_r2_age_step: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> alloc_age == age_t'($past(alloc_age) + 1'b1));
  a_r2_age_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_fire |=> $stable(alloc_age));
  a_r3_fwd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fwd_hit |-> ld_iss_valid && !ld_mem_rd && !ld_stall);
  a_r5_stall_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |-> !ld_mem_rd && !ld_fwd_hit);
  a_r6_store_replay_younger: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid && replay_cause[0] |-> st_res_valid && is_older(st_res_age, replay_age));
  a_r7_load_trap_younger: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid && replay_cause[1] |-> ld_iss_valid && is_older(ld_iss_age, replay_age));
  a_r9_ok_needs_query: assert property (@(posedge clk) disable iff (!rst_n)
    st_issue_ok |-> st_chk_valid);
endmodule

bind lsq_disambig lsq_disambig_chk u_chk (.*);

// File: tb/sim_lsq_disambig.sv
module sim_lsq_disambig;
  import lsq_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, alloc_valid, alloc_store, alloc_word, alloc_ready;
  addr_t alloc_addr;
  age_t alloc_age, ld_iss_age, st_res_age, st_chk_age, replay_age;
  logic ld_iss_valid, ld_fwd_hit, ld_stall, ld_mem_rd;
  data_t ld_fwd_data, st_res_data;
  logic st_res_valid, st_chk_valid, st_issue_ok, replay_valid, retire_valid;
  addr_t st_res_addr;
  logic [1:0] replay_cause;

  lsq_disambig u0 (.*);

  int checks = 0;
  int fails = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = 0; alloc_store = 0; alloc_word = 0; alloc_addr = '0;
    ld_iss_valid = 0; ld_iss_age = '0;
    st_res_valid = 0; st_res_age = '0; st_res_addr = '0; st_res_data = '0;
    st_chk_valid = 0; st_chk_age = '0; retire_valid = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_op();
    @(posedge clk);
    #1 idle();
  endtask

  task automatic alloc(input logic st, input logic w, input addr_t a, input age_t exp_age, input string req);
    @(negedge clk);
    alloc_valid = 1; alloc_store = st; alloc_word = w; alloc_addr = a;
    #1 chk(req, "alloc_age", 32'(alloc_age), 32'(exp_age));
    finish_op();
  endtask

  task automatic resolve(input age_t ag, input addr_t a, input data_t d,
                         output logic rv, output age_t ra, output logic [1:0] rc);
    @(negedge clk);
    st_res_valid = 1; st_res_age = ag; st_res_addr = a; st_res_data = d;
    #1 rv = replay_valid; ra = replay_age; rc = replay_cause;
    finish_op();
  endtask

  task automatic issue(input age_t ag, output logic hit, output data_t dat, output logic stl,
                       output logic rd, output logic rv, output age_t ra, output logic [1:0] rc);
    @(negedge clk);
    ld_iss_valid = 1; ld_iss_age = ag;
    #1 hit = ld_fwd_hit; dat = ld_fwd_data; stl = ld_stall; rd = ld_mem_rd;
    rv = replay_valid; ra = replay_age; rc = replay_cause;
    finish_op();
  endtask

  task automatic query(input age_t ag, output logic ok);
    @(negedge clk);
    st_chk_valid = 1; st_chk_age = ag;
    #1 ok = st_issue_ok;
    finish_op();
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1", "alloc_ready", 32'(alloc_ready), 1);
    chk("R1", "alloc_age", 32'(alloc_age), 0);
    chk("R1", "replay_valid", 32'(replay_valid), 0);
    chk("R1", "ld_mem_rd", 32'(ld_mem_rd), 0);
    chk("R1", "ld_fwd_hit", 32'(ld_fwd_hit), 0);
    chk("R1", "st_issue_ok", 32'(st_issue_ok), 0);
  endtask

  task automatic t_alloc_retire();
    do_reset();
    for (int i = 0; i < 4; i++) alloc(1, 1, '0, age_t'(i), "R2");
    @(negedge clk);
    alloc_store = 1;
    #1 chk("R2", "store queue full", 32'(alloc_ready), 0);
    alloc_store = 0;
    #1 chk("R2", "load queue still free", 32'(alloc_ready), 1);
    retire_valid = 1;
    finish_op();
    @(negedge clk);
    alloc_store = 1;
    #1 chk("R10", "slot back after retire", 32'(alloc_ready), 1);
    idle();
    alloc(1, 1, '0, 6'd4, "R10");
  endtask

  task automatic t_forward();
    logic hit, stl, rd, rv; data_t d; age_t ra; logic [1:0] rc;
    do_reset();
    alloc(1, 1, '0, 0, "R2");
    alloc(1, 1, '0, 1, "R2");
    alloc(0, 0, 16'h0102, 2, "R2");
    alloc(0, 0, 16'h0100, 3, "R2");
    alloc(0, 1, 16'h0100, 4, "R2");
    resolve(0, 16'h0100, 32'h11112222, rv, ra, rc);
    resolve(1, 16'h0100, 32'hAAAABBBB, rv, ra, rc);
    issue(2, hit, d, stl, rd, rv, ra, rc);
    chk("R3", "upper half hit", 32'(hit), 1);
    chk("R3", "upper half data youngest store", d, 32'h0000AAAA);
    chk("R3", "no mem read", 32'(rd), 0);
    issue(3, hit, d, stl, rd, rv, ra, rc);
    chk("R3", "lower half data", d, 32'h0000BBBB);
    issue(4, hit, d, stl, rd, rv, ra, rc);
    chk("R3", "word data", d, 32'hAAAABBBB);
  endtask

  task automatic t_mem_read();
    logic hit, stl, rd, rv; data_t d; age_t ra; logic [1:0] rc;
    do_reset();
    alloc(1, 1, '0, 0, "R2");
    alloc(0, 1, 16'h0200, 1, "R2");
    alloc(1, 1, '0, 2, "R2");
    resolve(2, 16'h0200, 32'hDEADBEEF, rv, ra, rc);
    chk("R4", "younger store resolve no replay", 32'(rv), 0);
    issue(1, hit, d, stl, rd, rv, ra, rc);
    chk("R4", "mem read", 32'(rd), 1);
    chk("R4", "no forward", 32'(hit), 0);
    chk("R4", "no stall", 32'(stl), 0);
  endtask

  task automatic t_narrow_store();
    logic hit, stl, rd, rv; data_t d; age_t ra; logic [1:0] rc;
    do_reset();
    alloc(1, 0, '0, 0, "R2");
    alloc(0, 1, 16'h0300, 1, "R2");
    alloc(0, 0, 16'h0300, 2, "R2");
    alloc(0, 0, 16'h0302, 3, "R2");
    resolve(0, 16'h0300, 32'h00001234, rv, ra, rc);
    issue(1, hit, d, stl, rd, rv, ra, rc);
    chk("R5", "word load stalls", 32'(stl), 1);
    chk("R5", "no mem read", 32'(rd), 0);
    chk("R5", "no forward", 32'(hit), 0);
    issue(2, hit, d, stl, rd, rv, ra, rc);
    chk("R3", "half to half forward", d, 32'h00001234);
    chk("R3", "half to half hit", 32'(hit), 1);
    issue(3, hit, d, stl, rd, rv, ra, rc);
    chk("R4", "other half reads memory", 32'(rd), 1);
    // stalled load stays not-issued: a store resolve on its word gives no replay from it
  endtask

  task automatic t_replay();
    logic hit, stl, rd, rv; data_t d; age_t ra; logic [1:0] rc;
    do_reset();
    alloc(1, 1, '0, 0, "R2");
    alloc(1, 1, '0, 1, "R2");
    alloc(0, 1, 16'h0400, 2, "R2");
    alloc(0, 1, 16'h0400, 3, "R2");
    alloc(0, 1, 16'h0500, 4, "R2");
    issue(2, hit, d, stl, rd, rv, ra, rc);
    issue(3, hit, d, stl, rd, rv, ra, rc);
    chk("R7", "in-order issue no trap", 32'(rv), 0);
    issue(4, hit, d, stl, rd, rv, ra, rc);
    resolve(1, 16'h0400, 32'h5555AAAA, rv, ra, rc);
    chk("R6", "replay raised", 32'(rv), 1);
    chk("R6", "oldest offender age", 32'(ra), 2);
    chk("R6", "cause store", 32'(rc), 2'b01);
    resolve(0, 16'h0500, 32'h0, rv, ra, rc);
    chk("R8", "replayed loads not issued", 32'(rv), 0);
    issue(3, hit, d, stl, rd, rv, ra, rc);
    chk("R7", "younger first no trap yet", 32'(rv), 0);
    issue(2, hit, d, stl, rd, rv, ra, rc);
    chk("R7", "load-load trap", 32'(rv), 1);
    chk("R7", "trap age", 32'(ra), 3);
    chk("R7", "trap cause", 32'(rc), 2'b10);
  endtask

  task automatic t_store_order();
    logic ok, hit, stl, rd, rv; data_t d; age_t ra; logic [1:0] rc;
    do_reset();
    alloc(0, 1, 16'h0600, 0, "R2");
    alloc(1, 1, '0, 1, "R2");
    alloc(1, 1, '0, 2, "R2");
    query(1, ok);
    chk("R9", "unresolved store blocked", 32'(ok), 0);
    resolve(1, 16'h0600, 32'h1, rv, ra, rc);
    query(1, ok);
    chk("R9", "older unissued load blocks", 32'(ok), 0);
    issue(0, hit, d, stl, rd, rv, ra, rc);
    query(1, ok);
    chk("R9", "store may proceed", 32'(ok), 1);
    resolve(2, 16'h0700, 32'h2, rv, ra, rc);
    query(2, ok);
    chk("R9", "non-overlapping store ok", 32'(ok), 1);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_alloc_retire();
    t_forward();
    t_mem_read();
    t_narrow_store();
    t_replay();
    t_store_order();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule